// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Counter

This block is a single 16-bit down-counting timer channel. It runs in one of three modes chosen by software: a rate generator that emits a one-tick low pulse once every N counter ticks, a square-wave generator that spends about half of every N ticks high and the rest low, and a software-started strobe that emits one low pulse N ticks after the count is written. Everything is synchronous to one system clock. The counter's own clock is supplied as a single-cycle enable pulse, `cnt_tick`. Each system-clock edge that carries this pulse counts as one counter clock.

Software first writes a mode, which parks the output high and waits for a count. It then writes a count. The count is taken into the counter on the next counter tick, and counting runs from there. The `gate` input has a separate job in each mode. In the two periodic modes a low level suspends the channel with its output high, and a rising edge restarts it from the full count. In strobe mode a low level only freezes the count.

Top module: `pic_channel`

## Requirements
- R1: After reset `out` is 1, and counter ticks without a written count leave it at 1.
- R2: `mode_wr` loads `mode_sel` (00 rate generator, 01 square wave, 10 strobe, 11 treated as rate generator). From the next edge on, `out` is 1 and stays 1 until a count has been written and loaded, even while ticks arrive.
- R3: A count written with `cnt_wr` is loaded on the next tick with `gate` high. `out` is 1 after that load tick, and counting runs on later ticks.
- R4: In rate-generator mode with count N of 2 or more, `out` is 0 for exactly the ticks whose number after the load tick, taken modulo N, equals N-1. It is 1 for all other ticks, which gives a period of N ticks.
- R5: In square-wave mode with an even count N, `out` is 1 for N/2 ticks, counting the load tick, and then 0 for N/2 ticks, repeating.
- R6: In square-wave mode with an odd count N of 3 or more, `out` is 1 for (N+1)/2 ticks and 0 for (N-1)/2 ticks, repeating.
- R7: In rate-generator and square-wave modes, `gate` low drives `out` to 1 by the next system-clock edge and halts counting. After `gate` rises, the next tick reloads the full count and the pattern restarts from its load tick.
- R8: In strobe mode `out` is 0 for exactly the one tick numbered N after the load tick. It is 1 before and after that tick, and counting stops once the pulse ends.
- R9: In strobe mode, ticks that arrive while `gate` is low do not advance the count.
- R10: In strobe mode, a count written while counting is in progress is loaded on the next tick and restarts the count from the new value.
- R11: A written count of 0 acts as 65536.
- R12: `out` never falls on a system-clock edge without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | One-cycle counter clock enable |
| gate | input | 1 | Gate level |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 2 | Mode code written by `mode_wr` |
| cnt_wr | input | 1 | Count write strobe |
| cnt_data | input | 16 | Count value written by `cnt_wr` |
| out | output | 1 | Timer output |

## Verification
`out` is a register. Every counter-driven change therefore appears right after the system-clock edge that carries `cnt_tick`. A count write takes effect only on the tick that follows it, and a falling `gate` shows on `out` one edge later. The bench queues one expected `out` value for each tick it drives. A monitor takes that value off the queue and compares it two nanoseconds after the ticking edge, while the pulse is still high. Level checks after a gate or mode change are made on the falling clock edge that follows the one updating edge. Expected patterns come from the tick number after the load tick, using the formulas in the requirements.

// File: rtl/pic_pkg.sv
// Package: shared mode type and mode-code decoding for the interval counter.
// Assumes a 2-bit mode code; code 11 is folded onto the rate generator.
package pic_pkg;
    typedef enum logic [1:0] {
        MODE_RATE   = 2'b00,
        MODE_SQUARE = 2'b01,
        MODE_STROBE = 2'b10
    } pic_mode_e;

    // Map the raw mode code onto a supported mode.
    function automatic pic_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_SQUARE;
            2'b10:   return MODE_STROBE;
            default: return MODE_RATE;
        endcase
    endfunction
endpackage

// File: rtl/pic_gate_track.sv
// Gate tracker: keeps the previous gate level and flags a rising edge.
// Assumes gate is already synchronous to clk.
module pic_gate_track (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    // Remember last cycle's gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pic_step_calc.sv
// Tick datapath: from the current count, output phase and mode, computes the
// state after one running counter tick. Purely combinational.
// Assumes the count holds at least 1 while running (0 written maps to 2**W).
module pic_step_calc
    import pic_pkg::*;
#(
    parameter int W = 16
) (
    input  pic_mode_e       mode_i,
    input  logic [W:0]      cnt_i,
    input  logic [W:0]      init_i,
    input  logic            out_i,
    input  logic            first_i,
    output logic [W:0]      cnt_o,
    output logic            out_o,
    output logic            first_o,
    output logic            done_o
);
    localparam int CW = W + 1;

    logic [CW-1:0] step;

    // Next-state selection for one tick in the active mode.
    always_comb begin
        cnt_o   = cnt_i;
        out_o   = out_i;
        first_o = first_i;
        done_o  = 1'b0;
        step    = CW'(2);
        case (mode_i)
            MODE_SQUARE: begin
                if (first_i && init_i[0])
                    step = out_i ? CW'(1) : CW'(3);
                if (cnt_i <= step) begin
                    cnt_o   = init_i;
                    out_o   = ~out_i;
                    first_o = 1'b1;
                end else begin
                    cnt_o   = cnt_i - step;
                    first_o = 1'b0;
                end
            end
            MODE_STROBE: begin
                if (!out_i) begin
                    out_o  = 1'b1;
                    done_o = 1'b1;
                end else if (cnt_i == CW'(1)) begin
                    out_o = 1'b0;
                    cnt_o = '0;
                end else begin
                    cnt_o = cnt_i - CW'(1);
                end
            end
            default: begin
                if (cnt_i == CW'(1)) begin
                    cnt_o = init_i;
                    out_o = 1'b1;
                end else begin
                    cnt_o = cnt_i - CW'(1);
                    out_o = (cnt_i != CW'(2));
                end
            end
        endcase
    end
endmodule

// File: rtl/pic_channel.sv
// Interval counter channel: holds mode, initial count and run state, applies
// the per-mode gate rules, and advances the count on each counter tick.
// Assumes all inputs are synchronous to clk and cnt_tick is one cycle wide.
module pic_channel
    import pic_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic         gate,
    input  logic         mode_wr,
    input  logic [1:0]   mode_sel,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_data,
    output logic         out
);
    localparam int CW = W + 1;

    pic_mode_e     mode_q;
    logic [CW-1:0] init_q, cnt_q, nx_cnt, load_val;
    logic          out_q, run_q, pend_q, armed_q, first_q;
    logic          nx_out, nx_first, nx_done, gate_rise, gated_mode;

    assign load_val   = {(cnt_data == '0), cnt_data};
    assign gated_mode = (mode_q != MODE_STROBE);
    assign out        = out_q;

    pic_gate_track u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate),
        .rise_o (gate_rise)
    );

    pic_step_calc #(.W(W)) u_step (
        .mode_i  (mode_q),
        .cnt_i   (cnt_q),
        .init_i  (init_q),
        .out_i   (out_q),
        .first_i (first_q),
        .cnt_o   (nx_cnt),
        .out_o   (nx_out),
        .first_o (nx_first),
        .done_o  (nx_done)
    );

    // Channel control: mode writes, count writes, gate rules and tick updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_RATE;
            init_q  <= '0;
            cnt_q   <= '0;
            out_q   <= 1'b1;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            first_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q  <= decode_mode(mode_sel);
            out_q   <= 1'b1;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (gated_mode && !gate) begin
                out_q <= 1'b1;
                run_q <= 1'b0;
            end else if (gated_mode && gate_rise && armed_q) begin
                pend_q <= 1'b1;
                run_q  <= 1'b0;
            end else if (cnt_tick && gate) begin
                if (pend_q) begin
                    cnt_q   <= init_q;
                    out_q   <= 1'b1;
                    run_q   <= 1'b1;
                    first_q <= 1'b1;
                    pend_q  <= 1'b0;
                end else if (run_q) begin
                    cnt_q   <= nx_cnt;
                    out_q   <= nx_out;
                    first_q <= nx_first;
                    if (nx_done) run_q <= 1'b0;
                end
            end
            if (cnt_wr) begin
                init_q  <= load_val;
                pend_q  <= 1'b1;
                armed_q <= 1'b1;
            end
        end
    end

    AST_MODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> out); // R2
    AST_GATE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_mode && !gate) |=> out); // R7
    AST_NO_IDLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> !$fell(out)); // R12
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STROBE && !out_q && cnt_tick && gate && !mode_wr) |=> out); // R8
    AST_SQ_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SQUARE && run_q && !first_q) |-> !cnt_q[0]); // R6
endmodule

// File: tb/tb_pic_channel.sv
module tb_pic_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        gate = 1'b1;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_data = '0;
    logic        out;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    bit    exp_q[$];
    bit    chk_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    pic_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .cnt_wr(cnt_wr),
        .cnt_data(cnt_data), .out(out)
    );

    // Monitor: scoreboard pop and compare just after each ticking edge.
    always @(posedge clk) begin
        #2;
        if (cnt_tick && exp_q.size() > 0) begin
            bit    e = exp_q.pop_front();
            bit    c = chk_q.pop_front();
            string t = tag_q.pop_front();
            if (c) begin
                checks++;
                if (out !== e) begin
                    errors++;
                    $display("FAIL %s: out=%b expected=%b", t, out, e);
                end
            end
        end
    end

    task automatic tick(input bit e, input bit c, input string t);
        @(negedge clk);
        cnt_tick = 1'b1;
        exp_q.push_back(e);
        chk_q.push_back(c);
        tag_q.push_back(t);
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic check_now(input bit e, input string t);
        checks++;
        if (out !== e) begin
            errors++;
            $display("FAIL %s: out=%b expected=%b", t, out, e);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_sel = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic write_count(input logic [15:0] n);
        @(negedge clk); cnt_wr = 1'b1; cnt_data = n;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic rate_ticks(input int n, input int i0, input int i1, input string t);
        for (int i = i0; i <= i1; i++) tick(((i % n) == n - 1) ? 1'b0 : 1'b1, 1'b1, t);
    endtask

    task automatic sq_ticks(input int n, input int i0, input int i1, input string t);
        for (int i = i0; i <= i1; i++) tick(((i % n) < (n + 1) / 2) ? 1'b1 : 1'b0, 1'b1, t);
    endtask

    task automatic strobe_ticks(input int n, input int i0, input int i1, input string t);
        for (int i = i0; i <= i1; i++) tick((i == n) ? 1'b0 : 1'b1, 1'b1, t);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: out=%b expected=finished run", out);
        summary();
    end

    // Driver: stimulus sequence with expected values pushed per tick.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now(1'b1, "R1 reset");
        tick(1'b1, 1'b1, "R1 idle tick");
        tick(1'b1, 1'b1, "R1 idle tick");

        // Rate generator, N=4.
        set_mode(2'b00);
        check_now(1'b1, "R2 after mode");
        tick(1'b1, 1'b1, "R2 no count");
        write_count(16'd4);
        tick(1'b1, 1'b1, "R3 load");
        rate_ticks(4, 1, 7, "R4 rate N=4");
        repeat (3) @(negedge clk);
        check_now(1'b0, "R12 no tick keeps low");
        @(negedge clk); gate = 1'b0;
        @(negedge clk);
        check_now(1'b1, "R7 gate low forces high");
        tick(1'b1, 1'b1, "R7 held while gate low");
        tick(1'b1, 1'b1, "R7 held while gate low");
        @(negedge clk); gate = 1'b1;
        tick(1'b1, 1'b1, "R7 reload after rise");
        rate_ticks(4, 1, 4, "R7 restart pattern");

        // Square wave, even and odd.
        set_mode(2'b01);
        write_count(16'd6);
        tick(1'b1, 1'b1, "R5 load");
        sq_ticks(6, 1, 12, "R5 square N=6");
        set_mode(2'b01);
        write_count(16'd5);
        tick(1'b1, 1'b1, "R6 load");
        sq_ticks(5, 1, 10, "R6 square N=5");
        @(negedge clk); gate = 1'b0;
        @(negedge clk);
        check_now(1'b1, "R7 square gate low");
        @(negedge clk); gate = 1'b1;
        tick(1'b1, 1'b1, "R7 square reload");
        sq_ticks(5, 1, 5, "R7 square restart");

        // Strobe.
        set_mode(2'b10);
        tick(1'b1, 1'b1, "R2 strobe no count");
        write_count(16'd3);
        tick(1'b1, 1'b1, "R3 strobe load");
        strobe_ticks(3, 1, 6, "R8 strobe N=3");
        write_count(16'd4);
        tick(1'b1, 1'b1, "R9 load");
        strobe_ticks(4, 1, 1, "R9 before hold");
        @(negedge clk); gate = 1'b0;
        tick(1'b1, 1'b1, "R9 held");
        tick(1'b1, 1'b1, "R9 held");
        tick(1'b1, 1'b1, "R9 held");
        @(negedge clk); gate = 1'b1;
        strobe_ticks(4, 2, 5, "R9 resumed");
        write_count(16'd5);
        tick(1'b1, 1'b1, "R10 load");
        strobe_ticks(5, 1, 2, "R10 first count");
        write_count(16'd2);
        tick(1'b1, 1'b1, "R10 reload tick");
        strobe_ticks(2, 1, 4, "R10 new count");

        // Mode rewrite mid-run parks output high.
        set_mode(2'b00);
        write_count(16'd3);
        tick(1'b1, 1'b1, "R3 load");
        rate_ticks(3, 1, 2, "R4 rate N=3");
        set_mode(2'b11);
        check_now(1'b1, "R2 mode rewrite high");
        tick(1'b1, 1'b1, "R2 waits for count");

        // Count 0 as 65536 in square-wave mode.
        set_mode(2'b01);
        write_count(16'd0);
        tick(1'b1, 1'b1, "R11 load");
        for (int i = 1; i <= 32768; i++)
            tick((i < 32768) ? 1'b1 : 1'b0, (i >= 32767) ? 1'b1 : 1'b0, "R11 count zero");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule